// File: doc/BRIEF.md
# Metadata Address Translation Buffer

This block is a small fully associative lookup table used by an instruction-grain program monitor. The monitor keeps shadow metadata for every application byte or word, arranged as a two-level map. Each entry here caches one first-level result: for one aligned application region it holds the base of the second-level metadata chunk and the element scale that says how many metadata bytes stand behind one application byte. A lookup request carries an application address. One cycle later the block answers with either the metadata address or a miss.

On a miss the block reports the faulting application address. Monitoring software running in user mode then walks the map itself and installs the entry with a fill command. Software can also drop one entry by region tag or flush the whole table. A new region takes a slot picked by a round-robin pointer. A fill for a region that is already present rewrites that entry in place, so a tag never sits in two slots.

With default parameters an application address has 32 bits. The low 12 bits are the in-region offset and the upper 20 bits are the region tag. The table has 16 entries.

Top module: `mdat_xbuf`

## Requirements
- R1: After synchronous reset every entry is invalid and rsp_valid is 0, so the first lookup misses.
- R2: A lookup whose tag (lk_addr[31:12]) matches a valid entry gives rsp_valid=1, rsp_hit=1 and rsp_miss=0 on the next cycle. rsp_meta is then the entry base plus the scaled offset.
- R3: The scale is a 3-bit two's complement code s in the range -2..+3. The offset lk_addr[11:0] is shifted left by s when s is 0 or more, and right by -s (dropping low bits) when s is negative, before it is added to the base.
- R4: A lookup with no matching valid entry gives rsp_miss=1 and rsp_hit=0 on the next cycle, with rsp_fault equal to the requested address.
- R5: A fill for a region not in the table is written to the slot named by a round-robin pointer, which then advances modulo 16. The seventeenth distinct fill therefore evicts the oldest one.
- R6: A fill for a region already in the table overwrites that entry's base and scale in place and does not advance the pointer.
- R7: An invalidate removes only the entry whose tag equals inv_tag. Other entries keep answering.
- R8: A flush makes every entry invalid.
- R9: Only one table command takes effect per cycle, with priority flush, then invalidate, then fill. A fill that loses is dropped.
- R10: A fill whose scale code is 3'b100 or 3'b101 (-4 or -3) is ignored.
- R11: A lookup sees the table as it was before any command in the same cycle. A fill becomes visible to lookups from the next cycle.
- R12: rsp_valid is 1 exactly in the cycle after a cycle with lk_valid=1. When rsp_valid is 0, rsp_hit and rsp_miss are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Application address to translate |
| fill_en | input | 1 | Install or rewrite an entry |
| fill_tag | input | 20 | Region tag for the fill |
| fill_base | input | 32 | Metadata chunk base for the fill |
| fill_scale | input | 3 | Signed element scale code for the fill |
| inv_en | input | 1 | Invalidate one entry by tag |
| inv_tag | input | 20 | Region tag to invalidate |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_miss | output | 1 | Response is a miss |
| rsp_meta | output | 32 | Translated metadata address (hit only) |
| rsp_fault | output | 32 | Application address that missed |

## Verification
The bench walks all six legal scale codes across offsets from 0 to the top of a region. A right shift that kept rounding bits, or a left shift that was cut to the offset width, would produce a wrong metadata address. It fills all sixteen slots, rewrites one region, and then adds a new one. A buffer that advanced its pointer on a rewrite would evict the second-oldest region instead of the oldest. A buffer that duplicated the tag would keep serving the stale base. It also sends conflicting commands in the same cycle, illegal scale codes, and a lookup in the same cycle as the fill of the tag being looked up. Wrong priority, an accepted illegal scale, or a table that bypasses the write would each show up as a hit where a miss is due.

// File: rtl/mdxb_pkg.sv
package mdxb_pkg;

    typedef logic signed [2:0] mscale_t;

    localparam int SCALE_LO = -2;
    localparam int SCALE_HI = 3;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FILL  = 2'd1,
        OP_INV   = 2'd2,
        OP_FLUSH = 2'd3
    } tbl_op_e;

    function automatic logic scale_legal(input mscale_t s);
        return (int'(s) >= SCALE_LO) && (int'(s) <= SCALE_HI);
    endfunction

    // flush beats invalidate beats fill
    function automatic tbl_op_e pick_op(input logic fl, input logic inv,
                                        input logic wr, input logic legal);
        if (fl)
            return OP_FLUSH;
        if (inv)
            return OP_INV;
        if (wr && legal)
            return OP_FILL;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/mdxb_victim.sv
module mdxb_victim #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (advance)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/mdxb_entries.sv
module mdxb_entries import mdxb_pkg::*; #(
    parameter int N      = 16,
    parameter int TAG_W  = 20,
    parameter int BASE_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  tbl_op_e           op,
    input  logic [TAG_W-1:0]  op_tag,
    input  logic [BASE_W-1:0] op_base,
    input  mscale_t           op_scale,
    input  logic [IDX_W-1:0]  victim,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [BASE_W-1:0] look_base,
    output mscale_t           look_scale,
    output logic              op_present,
    output logic [N-1:0]      valid_vec
);

    logic [TAG_W-1:0]  tag_q   [N];
    logic [BASE_W-1:0] base_q  [N];
    mscale_t           scale_q [N];
    logic              vld_q   [N];
    logic [N-1:0]      op_match;
    logic [N-1:0]      lk_match;

    assign op_present = |op_match;
    assign look_hit   = |lk_match;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic wr_sel;

        assign op_match[i]  = vld_q[i] && (tag_q[i] == op_tag);
        assign lk_match[i]  = vld_q[i] && (tag_q[i] == look_tag);
        assign valid_vec[i] = vld_q[i];
        assign wr_sel       = op_present ? op_match[i] : (victim == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i] <= 1'b0;
            end else begin
                unique case (op)
                    OP_FLUSH: vld_q[i] <= 1'b0;
                    OP_INV:   if (op_match[i]) vld_q[i] <= 1'b0;
                    OP_FILL:  if (wr_sel)      vld_q[i] <= 1'b1;
                    default:  ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (op == OP_FILL && wr_sel) begin
                tag_q[i]   <= op_tag;
                base_q[i]  <= op_base;
                scale_q[i] <= op_scale;
            end
        end
    end

    // tags are unique, so at most one slot matches and OR-ing selects it
    always_comb begin
        look_base  = '0;
        look_scale = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) begin
                look_base  = look_base  | base_q[i];
                look_scale = look_scale | scale_q[i];
            end
        end
    end

endmodule

// File: rtl/mdxb_xlate.sv
module mdxb_xlate import mdxb_pkg::*; #(
    parameter int OFF_W  = 12,
    parameter int BASE_W = 32,
    localparam int SH_W  = OFF_W + SCALE_HI
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [BASE_W-1:0] base,
    input  mscale_t           scale,
    output logic [BASE_W-1:0] meta
);

    logic [SH_W-1:0] ext;
    logic [SH_W-1:0] shifted;
    logic [2:0]      code;

    assign ext  = SH_W'(off);
    assign code = scale;

    always_comb begin
        case (code)
            3'b001:  shifted = ext << 1;
            3'b010:  shifted = ext << 2;
            3'b011:  shifted = ext << 3;
            3'b111:  shifted = ext >> 1;
            3'b110:  shifted = ext >> 2;
            default: shifted = ext;
        endcase
    end

    assign meta = base + BASE_W'(shifted);

endmodule

// File: rtl/mdat_xbuf.sv
module mdat_xbuf import mdxb_pkg::*; #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 16,
    parameter int BASE_W  = 32,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [BASE_W-1:0] fill_base,
    input  logic [2:0]        fill_scale,
    input  logic              inv_en,
    input  logic [TAG_W-1:0]  inv_tag,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [BASE_W-1:0] rsp_meta,
    output logic [ADDR_W-1:0] rsp_fault
);

    tbl_op_e           op;
    mscale_t           w_scale;
    logic [TAG_W-1:0]  op_tag;
    logic [IDX_W-1:0]  victim;
    logic              op_present;
    logic              advance;
    logic              hit;
    logic [BASE_W-1:0] hit_base;
    mscale_t           hit_scale;
    logic [BASE_W-1:0] meta;
    logic [ENTRIES-1:0] ent_valid;

    assign w_scale = mscale_t'(fill_scale);
    assign op      = pick_op(flush, inv_en, fill_en, scale_legal(w_scale));
    assign op_tag  = (op == OP_INV) ? inv_tag : fill_tag;
    assign advance = (op == OP_FILL) && !op_present;

    mdxb_victim #(.N(ENTRIES)) u_victim (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .ptr     (victim)
    );

    mdxb_entries #(.N(ENTRIES), .TAG_W(TAG_W), .BASE_W(BASE_W)) u_entries (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .op_tag     (op_tag),
        .op_base    (fill_base),
        .op_scale   (w_scale),
        .victim     (victim),
        .look_tag   (lk_addr[ADDR_W-1:OFF_W]),
        .look_hit   (hit),
        .look_base  (hit_base),
        .look_scale (hit_scale),
        .op_present (op_present),
        .valid_vec  (ent_valid)
    );

    mdxb_xlate #(.OFF_W(OFF_W), .BASE_W(BASE_W)) u_xlate (
        .off   (lk_addr[OFF_W-1:0]),
        .base  (hit_base),
        .scale (hit_scale),
        .meta  (meta)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_meta  <= '0;
            rsp_fault <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && hit;
            rsp_miss  <= lk_valid && !hit;
            rsp_meta  <= (lk_valid && hit)  ? meta    : '0;
            rsp_fault <= (lk_valid && !hit) ? lk_addr : '0;
        end
    end

endmodule

// File: rtl/mdat_xbuf_chk.sv
module mdat_xbuf_chk #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic [ADDR_W-1:0]  lk_addr,
    input logic               fill_en,
    input logic [2:0]         fill_scale,
    input logic               inv_en,
    input logic               flush,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic [ADDR_W-1:0]  rsp_fault,
    input logic [ENTRIES-1:0] valid_vec
);

    logic bad_scale;
    assign bad_scale = (fill_scale == 3'b100) || (fill_scale == 3'b101);

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss)); // R12

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid); // R12

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid); // R12

    AST_FAULT_ECHO: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!rsp_miss || (rsp_fault == $past(lk_addr)))); // R4

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0)); // R8

    AST_BAD_SCALE_DROP: assert property (@(posedge clk) disable iff (rst)
        (fill_en && bad_scale && !inv_en && !flush) |=> $stable(valid_vec)); // R10

    AST_INV_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        (inv_en && !flush) |=> ($countones(valid_vec) <= $past($countones(valid_vec)))); // R7

endmodule

bind mdat_xbuf mdat_xbuf_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_addr    (lk_addr),
    .fill_en    (fill_en),
    .fill_scale (fill_scale),
    .inv_en     (inv_en),
    .flush      (flush),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_fault  (rsp_fault),
    .valid_vec  (ent_valid)
);

// File: tb/sim_mdat_xbuf.sv
`timescale 1ns/1ps
module sim_mdat_xbuf;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic        fill_en;
    logic [19:0] fill_tag;
    logic [31:0] fill_base;
    logic [2:0]  fill_scale;
    logic        inv_en;
    logic [19:0] inv_tag;
    logic        flush;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [31:0] rsp_meta, rsp_fault;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    mdat_xbuf u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_en(fill_en), .fill_tag(fill_tag), .fill_base(fill_base),
        .fill_scale(fill_scale), .inv_en(inv_en), .inv_tag(inv_tag),
        .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_meta(rsp_meta), .rsp_fault(rsp_fault)
    );

    localparam int          NF = 6;
    localparam logic [19:0] TAGV  [NF] = '{20'h00010, 20'h00020, 20'h00030,
                                           20'h00040, 20'h00050, 20'h00060};
    localparam logic [31:0] BASEV [NF] = '{32'h8000_0000, 32'h8010_0000, 32'h8020_0000,
                                           32'h8030_0000, 32'h8040_0000, 32'h8050_0000};
    localparam int          SCV   [NF] = '{0, 1, 2, 3, -1, -2};

    localparam int          NV = 8;
    localparam logic [31:0] LKA [NV] = '{32'h0001_0ABC, 32'h0002_0FFF, 32'h0003_0001,
                                         32'h0004_0FFF, 32'h0005_0003, 32'h0006_0007,
                                         32'h0007_0000, 32'h0001_0000};
    localparam int          LKE [NV] = '{0, 1, 2, 3, 4, 5, -1, 0};

    function automatic logic [31:0] exp_meta(input logic [31:0] base, input int sc,
                                             input logic [31:0] addr);
        logic [31:0] off;
        off = {20'b0, addr[11:0]};
        if (sc >= 0)
            return base + (off << sc);
        return base + (off >> (-sc));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 1'b0; lk_addr = '0; fill_en = 1'b0; fill_tag = '0;
        fill_base = '0; fill_scale = '0; inv_en = 1'b0; inv_tag = '0; flush = 1'b0;
    endtask

    task automatic do_fill(input logic [19:0] t, input logic [31:0] b, input int s);
        fill_en = 1'b1; fill_tag = t; fill_base = b; fill_scale = 3'(s);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] a);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] a, input logic [31:0] m);
        do_lookup(a);
        chk(req, {29'b0, rsp_valid, rsp_hit, rsp_miss}, 32'b110);
        chk(req, rsp_meta, m);
    endtask

    task automatic expect_miss(input string req, input logic [31:0] a);
        do_lookup(a);
        chk(req, {29'b0, rsp_valid, rsp_hit, rsp_miss}, 32'b101);
        chk(req, rsp_fault, a);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        expect_miss("R1 empty after reset", 32'h0001_0ABC);
        @(negedge clk);
        chk("R12 no request no response", {29'b0, rsp_valid, rsp_hit, rsp_miss}, 32'd0);

        for (int i = 0; i < NF; i++) do_fill(TAGV[i], BASEV[i], SCV[i]);

        // vector walk: R2 hits, R3 scales, R4 misses
        for (int v = 0; v < NV; v++) begin
            if (LKE[v] < 0)
                expect_miss("R4 vector miss", LKA[v]);
            else
                expect_hit("R2 R3 vector hit", LKA[v],
                           exp_meta(BASEV[LKE[v]], SCV[LKE[v]], LKA[v]));
        end

        // R11: fill and lookup of the same tag in one cycle
        fill_en = 1'b1; fill_tag = 20'h00080; fill_base = 32'h9000_0000; fill_scale = 3'd0;
        lk_valid = 1'b1; lk_addr = 32'h0008_0010;
        @(negedge clk);
        idle_inputs();
        chk("R11 same-cycle lookup misses", {31'b0, rsp_miss}, 32'd1);
        expect_hit("R11 next-cycle hit", 32'h0008_0010, 32'h9000_0010);

        // R10: illegal scale codes dropped
        do_fill(20'h00090, 32'hA000_0000, -4);
        do_fill(20'h00091, 32'hA100_0000, -3);
        expect_miss("R10 scale -4 ignored", 32'h0009_0000);
        expect_miss("R10 scale -3 ignored", 32'h0009_1000);

        // R7: invalidate one tag
        inv_en = 1'b1; inv_tag = 20'h00020;
        @(negedge clk);
        inv_en = 1'b0;
        expect_miss("R7 invalidated tag misses", 32'h0002_0000);
        expect_hit("R7 neighbour survives", 32'h0003_0004, exp_meta(BASEV[2], SCV[2], 32'h0003_0004));

        // R9: invalidate beats fill in the same cycle
        inv_en = 1'b1; inv_tag = 20'h000BB;
        fill_en = 1'b1; fill_tag = 20'h000B0; fill_base = 32'hB000_0000; fill_scale = 3'd0;
        @(negedge clk);
        idle_inputs();
        expect_miss("R9 fill dropped under invalidate", 32'h000B_0000);

        // R9 and R8: flush beats fill and empties the table
        flush = 1'b1;
        fill_en = 1'b1; fill_tag = 20'h000A0; fill_base = 32'hC000_0000; fill_scale = 3'd0;
        @(negedge clk);
        idle_inputs();
        expect_miss("R9 fill dropped under flush", 32'h000A_0000);
        expect_miss("R8 flushed entry misses", 32'h0001_0ABC);
        expect_miss("R8 flushed entry misses", 32'h0008_0010);

        // R5 and R6: fill all slots, rewrite one, then add one more
        for (int i = 0; i < 16; i++) do_fill(20'h00100 + 20'(i), 32'(i) << 16, 0);
        do_fill(20'h00105, 32'hABC0_0000, 0);
        do_fill(20'h00110, 32'hDD00_0000, 0);
        expect_miss("R5 oldest evicted", 32'h0010_0000);
        expect_hit("R6 rewrite kept pointer", 32'h0010_1020, 32'h0001_0020);
        expect_hit("R6 rewritten base", 32'h0010_5008, 32'hABC0_0008);
        expect_hit("R5 new entry", 32'h0011_0FFF, 32'hDD00_0FFF);
        expect_hit("R5 last of first round", 32'h0010_F001, 32'h000F_0001);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule